// File: doc/BRIEF.md
# Paired-Read Prefetch Value Cache

This block sits at the host-facing end of a layered memory bridge. The host issues reads with a fixed read latency, but the memory behind the bridge is too far away to answer within that window. Software therefore reads each far location twice: once through its normal address and once through an alias that differs only in the top address bit. The block tells the two reads apart by whether it already holds an entry for the address.

On the first read (a lookup miss) the block claims an entry, sends the read downstream tagged with that entry's number, and answers the host on time with a placeholder line. Downstream data later comes back carrying the entry number and is stored there. On the second read (a lookup hit) the block answers with the stored line and releases the entry. If the data has not yet come back, the block answers with the placeholder again and keeps the entry, so that software retries. Every host beat leaves the block exactly TRL cycles after its read, whichever path was taken.

Top module: `paired_read_cache`

## Requirements
- R1: During and right after reset no entry is held, `fwd_valid` and `host_valid` are low, and the first read after reset is a miss.
- R2: A read whose masked address matches no held entry raises `fwd_valid` in the next cycle, with `fwd_addr` equal to the read address with the alias bit cleared and `fwd_id` naming the entry claimed. A read that hits forwards nothing.
- R3: A read with `rd_valid` high in cycle c gives exactly one host beat, with `host_valid` high in cycle c+TRL. `host_valid` is low in every other cycle.
- R4: A miss beat has `host_fake` = 1 and every byte of `host_data` equal to 0x5A.
- R5: A return whose `ret_id` names an entry that is not awaiting data is ignored. The line already stored there is unchanged.
- R6: A hit on an entry whose data has returned gives `host_fake` = 0 and `host_data` equal to the returned line. The entry is then freed, so the next read of that address misses.
- R7: Address bit ALIAS_BIT (default 31, the top bit) is left out of tag comparison. An address and its alias reach the same entry.
- R8: A hit on an entry still awaiting data gives `host_fake` = 1 and the 0x5A placeholder. It forwards nothing and keeps the entry, so a read after the data returns hits.
- R9: When a return and a hit name the same awaiting entry in the same cycle, the returned line goes to the host with `host_fake` = 0 and the entry is freed.
- R10: The entry a miss claims is the lowest-numbered free entry. If no entry is free, it is the least recently claimed entry whose data has returned. If every entry is still awaiting data, it is the least recently claimed entry.
- R11: Once an address's entry has been taken for another address, a read of that address is a fresh miss: a new entry, a new forward and a placeholder beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_valid | input | 1 | Host read strobe |
| rd_addr | input | ADDR_W | Reconstructed read address |
| ret_valid | input | 1 | Downstream data strobe |
| ret_id | input | ID_W | Entry number for the returned line |
| ret_data | input | DATA_W | Returned line |
| fwd_valid | output | 1 | Downstream read request strobe |
| fwd_addr | output | ADDR_W | Read address with the alias bit cleared |
| fwd_id | output | ID_W | Entry claimed for the request |
| host_valid | output | 1 | Host read beat strobe |
| host_fake | output | 1 | Beat carries the placeholder, not real data |
| host_data | output | DATA_W | Beat data |

## Verification
Two functions can fall in the same cycle: a downstream return being written into an entry, and a host lookup that hits that same entry while it is still awaiting data. The bench provokes this by driving the second read of an address in the very cycle that the address's return is presented. It expects the returned line, not the placeholder, to reach the host TRL cycles later, and it expects the entry to be free afterwards. A behavioural reference model, updated on each clock, predicts every forward and every host beat. Random traffic with returns in random order also produces the collision, along with the case where a claim coincides with a stray return.

// File: rtl/prc_pkg.sv
package prc_pkg;

    // Byte repeated across a placeholder line
    localparam logic [7:0] FILL_BYTE = 8'h5A;

    // How a host beat was produced
    typedef enum logic [1:0] {
        RESP_FILL_MISS = 2'd0,
        RESP_FILL_PEND = 2'd1,
        RESP_DATA      = 2'd2,
        RESP_BYPASS    = 2'd3
    } resp_e;

endpackage

// File: rtl/prc_tag_match.sv
module prc_tag_match #(
    parameter int ADDR_W = 32,
    parameter int DEPTH  = 16,
    parameter int ID_W   = 4
) (
    input  logic [DEPTH-1:0]             valid_i,
    input  logic [DEPTH-1:0][ADDR_W-1:0] tag_i,
    input  logic [ADDR_W-1:0]            key_i,
    output logic [DEPTH-1:0]             hit_vec_o,
    output logic                         hit_o,
    output logic [ID_W-1:0]              hit_idx_o
);

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign hit_vec_o[g] = valid_i[g] && (tag_i[g] == key_i);
    end

    assign hit_o = |hit_vec_o;

    always_comb begin
        hit_idx_o = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (hit_vec_o[i]) begin
                hit_idx_o = ID_W'(i);
            end
        end
    end

endmodule

// File: rtl/prc_lru.sv
module prc_lru #(
    parameter int DEPTH = 16,
    parameter int ID_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             touch_i,
    input  logic [ID_W-1:0]  touch_id_i,
    input  logic [DEPTH-1:0] valid_i,
    input  logic [DEPTH-1:0] pend_i,
    output logic [ID_W-1:0]  victim_o
);

    // rank 0 = most recently claimed, DEPTH-1 = least recently claimed
    typedef struct packed {
        logic [DEPTH-1:0][ID_W-1:0] rank;
    } lru_state_t;

    lru_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (touch_i) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (st_q.rank[i] < st_q.rank[touch_id_i]) begin
                    st_d.rank[i] = st_q.rank[i] + 1'b1;
                end
            end
            st_d.rank[touch_id_i] = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                st_q.rank[i] <= ID_W'(i);
            end
        end else begin
            st_q <= st_d;
        end
    end

    // Victim: lowest free, else oldest completed, else oldest overall
    logic            free_found;
    logic [ID_W-1:0] free_idx;
    logic            done_found;
    logic [ID_W-1:0] done_idx;
    logic [ID_W-1:0] done_rank;
    logic [ID_W-1:0] any_idx;
    logic [ID_W-1:0] any_rank;

    always_comb begin
        free_found = 1'b0;
        free_idx   = '0;
        done_found = 1'b0;
        done_idx   = '0;
        done_rank  = '0;
        any_idx    = '0;
        any_rank   = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (!valid_i[i] && !free_found) begin
                free_found = 1'b1;
                free_idx   = ID_W'(i);
            end
            if (valid_i[i] && !pend_i[i] && (!done_found || st_q.rank[i] > done_rank)) begin
                done_found = 1'b1;
                done_idx   = ID_W'(i);
                done_rank  = st_q.rank[i];
            end
            if (i == 0 || st_q.rank[i] > any_rank) begin
                any_idx  = ID_W'(i);
                any_rank = st_q.rank[i];
            end
        end
        if (free_found) begin
            victim_o = free_idx;
        end else if (done_found) begin
            victim_o = done_idx;
        end else begin
            victim_o = any_idx;
        end
    end

    // R10: a free entry is always taken before a held one
    p_free_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!(&valid_i)) |-> !valid_i[victim_o]);

    // R10: a completed entry is taken before one still awaiting data
    p_done_before_pend_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((&valid_i) && !(&pend_i)) |-> !pend_i[victim_o]);

endmodule

// File: rtl/prc_beat_delay.sv
module prc_beat_delay #(
    parameter int DATA_W = 64,
    parameter int TRL    = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid_i,
    input  prc_pkg::resp_e       in_kind_i,
    input  logic [DATA_W-1:0]    in_data_i,
    output logic                 out_valid_o,
    output prc_pkg::resp_e       out_kind_o,
    output logic [DATA_W-1:0]    out_data_o
);

    typedef struct packed {
        logic              vld;
        prc_pkg::resp_e    kind;
        logic [DATA_W-1:0] data;
    } beat_t;

    beat_t [TRL-1:0] st_q, st_d;

    always_comb begin
        st_d[0].vld  = in_valid_i;
        st_d[0].kind = in_kind_i;
        st_d[0].data = in_data_i;
        for (int i = 1; i < TRL; i++) begin
            st_d[i] = st_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < TRL; i++) begin
                st_q[i].vld  <= 1'b0;
                st_q[i].kind <= prc_pkg::RESP_FILL_MISS;
                st_q[i].data <= '0;
            end
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid_o = st_q[TRL-1].vld;
    assign out_kind_o  = st_q[TRL-1].kind;
    assign out_data_o  = st_q[TRL-1].data;

endmodule

// File: rtl/paired_read_cache.sv
module paired_read_cache #(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 64,
    parameter int DEPTH     = 16,
    parameter int TRL       = 4,
    parameter int ALIAS_BIT = ADDR_W - 1,
    parameter int ID_W      = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_valid,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              ret_valid,
    input  logic [ID_W-1:0]   ret_id,
    input  logic [DATA_W-1:0] ret_data,
    output logic              fwd_valid,
    output logic [ADDR_W-1:0] fwd_addr,
    output logic [ID_W-1:0]   fwd_id,
    output logic              host_valid,
    output logic              host_fake,
    output logic [DATA_W-1:0] host_data
);

    import prc_pkg::*;

    localparam logic [ADDR_W-1:0] ALIAS_MASK =
        ~({{(ADDR_W-1){1'b0}}, 1'b1} << ALIAS_BIT);
    localparam logic [DATA_W-1:0] FILL_LINE = {(DATA_W/8){FILL_BYTE}};
    localparam int BEAT_CNT_W = $clog2(TRL + 1) + 1;

    typedef struct packed {
        logic [DEPTH-1:0]             valid;
        logic [DEPTH-1:0]             pend;
        logic [DEPTH-1:0][ADDR_W-1:0] tag;
        logic [DEPTH-1:0][DATA_W-1:0] data;
        logic                         fwd_valid;
        logic [ADDR_W-1:0]            fwd_addr;
        logic [ID_W-1:0]              fwd_id;
    } state_t;

    state_t s_q, s_d;

    logic [ADDR_W-1:0] key;
    logic [DEPTH-1:0]  hit_vec;
    logic              hit;
    logic [ID_W-1:0]   hit_idx;
    logic [ID_W-1:0]   victim;
    logic              look_hit;
    logic              alloc;
    logic              ret_live;
    logic              bypass;
    resp_e             beat_kind;
    logic [DATA_W-1:0] beat_data;
    resp_e             out_kind;

    assign key = rd_addr & ALIAS_MASK;

    prc_tag_match #(
        .ADDR_W (ADDR_W),
        .DEPTH  (DEPTH),
        .ID_W   (ID_W)
    ) u_match (
        .valid_i   (s_q.valid),
        .tag_i     (s_q.tag),
        .key_i     (key),
        .hit_vec_o (hit_vec),
        .hit_o     (hit),
        .hit_idx_o (hit_idx)
    );

    prc_lru #(
        .DEPTH (DEPTH),
        .ID_W  (ID_W)
    ) u_lru (
        .clk        (clk),
        .rst_n      (rst_n),
        .touch_i    (alloc),
        .touch_id_i (victim),
        .valid_i    (s_q.valid),
        .pend_i     (s_q.pend),
        .victim_o   (victim)
    );

    always_comb begin
        look_hit = rd_valid && hit;
        alloc    = rd_valid && !hit;
        ret_live = ret_valid && s_q.valid[ret_id] && s_q.pend[ret_id];
        bypass   = look_hit && s_q.pend[hit_idx] && ret_live && (ret_id == hit_idx);

        // beat decision is taken at lookup time
        if (!look_hit) begin
            beat_kind = RESP_FILL_MISS;
            beat_data = FILL_LINE;
        end else if (!s_q.pend[hit_idx]) begin
            beat_kind = RESP_DATA;
            beat_data = s_q.data[hit_idx];
        end else if (bypass) begin
            beat_kind = RESP_BYPASS;
            beat_data = ret_data;
        end else begin
            beat_kind = RESP_FILL_PEND;
            beat_data = FILL_LINE;
        end

        s_d = s_q;

        // downstream fill of an awaiting entry
        if (ret_live) begin
            s_d.data[ret_id] = ret_data;
            s_d.pend[ret_id] = 1'b0;
        end

        // demand read consumes a completed (or just completing) entry
        if (look_hit && (!s_q.pend[hit_idx] || bypass)) begin
            s_d.valid[hit_idx] = 1'b0;
            s_d.pend[hit_idx]  = 1'b0;
        end

        // first read claims an entry; a claim overrides a same-cycle fill
        if (alloc) begin
            s_d.valid[victim] = 1'b1;
            s_d.pend[victim]  = 1'b1;
            s_d.tag[victim]   = key;
        end

        s_d.fwd_valid = alloc;
        s_d.fwd_addr  = key;
        s_d.fwd_id    = victim;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    prc_beat_delay #(
        .DATA_W (DATA_W),
        .TRL    (TRL)
    ) u_delay (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid_i  (rd_valid),
        .in_kind_i   (beat_kind),
        .in_data_i   (beat_data),
        .out_valid_o (host_valid),
        .out_kind_o  (out_kind),
        .out_data_o  (host_data)
    );

    assign host_fake = (out_kind == RESP_FILL_MISS) || (out_kind == RESP_FILL_PEND);
    assign fwd_valid = s_q.fwd_valid;
    assign fwd_addr  = s_q.fwd_addr;
    assign fwd_id    = s_q.fwd_id;

    // ---------------- assertions ----------------

    // reads minus delivered beats, kept only for checking
    logic [BEAT_CNT_W-1:0] beats_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            beats_q <= '0;
        end else begin
            beats_q <= beats_q + BEAT_CNT_W'(rd_valid) - BEAT_CNT_W'(host_valid);
        end
    end

    // R3: never more reads outstanding than the latency window holds
    p_beat_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        beats_q <= BEAT_CNT_W'(TRL));

    // R3: a beat only leaves for a read that was taken
    p_beat_has_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        host_valid |-> (beats_q != '0));

    // R2: a forward only follows a read
    p_fwd_after_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid |-> $past(rd_valid));

    // R2: a claimed entry is held and awaiting data afterwards
    p_claim_marks_r2: assert property (@(posedge clk) disable iff (!rst_n)
        alloc |=> (s_q.valid[$past(victim)] && s_q.pend[$past(victim)]));

    // R6: a completed hit frees its entry
    p_hit_frees_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (look_hit && !s_q.pend[hit_idx]) |=> !s_q.valid[$past(hit_idx)]);

    // R8: a hit while still awaiting data keeps the entry
    p_pend_hit_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (look_hit && s_q.pend[hit_idx] && !bypass) |=> s_q.valid[$past(hit_idx)]);

    // R7: one address (alias included) lives in at most one entry
    p_one_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

endmodule

// File: tb/paired_read_cache_tb_top.sv
module paired_read_cache_tb_top;

    localparam int AW  = 32;
    localparam int DW  = 64;
    localparam int DEP = 16;
    localparam int TRL = 4;
    localparam int IDW = 4;
    localparam logic [AW-1:0] MASK = 32'h7FFF_FFFF;
    localparam logic [AW-1:0] ALIAS = 32'h8000_0000;
    localparam logic [DW-1:0] FILL = {8{8'h5A}};

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           rd_valid = 1'b0;
    logic [AW-1:0]  rd_addr = '0;
    logic           ret_valid = 1'b0;
    logic [IDW-1:0] ret_id = '0;
    logic [DW-1:0]  ret_data = '0;
    logic           fwd_valid;
    logic [AW-1:0]  fwd_addr;
    logic [IDW-1:0] fwd_id;
    logic           host_valid;
    logic           host_fake;
    logic [DW-1:0]  host_data;

    always #5 clk = ~clk;

    paired_read_cache #(
        .ADDR_W (AW),
        .DATA_W (DW),
        .DEPTH  (DEP),
        .TRL    (TRL)
    ) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_valid   (rd_valid),
        .rd_addr    (rd_addr),
        .ret_valid  (ret_valid),
        .ret_id     (ret_id),
        .ret_data   (ret_data),
        .fwd_valid  (fwd_valid),
        .fwd_addr   (fwd_addr),
        .fwd_id     (fwd_id),
        .host_valid (host_valid),
        .host_fake  (host_fake),
        .host_data  (host_data)
    );

    int    checks = 0;
    int    fails  = 0;
    int    cyc    = 0;
    bit    done   = 1'b0;
    string phase  = "";

    // reference model state
    bit            m_valid[DEP];
    bit            m_pend[DEP];
    logic [AW-1:0] m_tag[DEP];
    logic [DW-1:0] m_data[DEP];
    int            m_stamp[DEP];

    // expectations keyed by edge number
    logic [AW-1:0] ef_a[int];
    int            ef_id[int];
    string         ef_req[int];
    bit            eh_fake[int];
    logic [DW-1:0] eh_d[int];
    string         eh_req[int];

    // bench bookkeeping for stimulus
    int            id_of[logic [AW-1:0]];
    int            outq_id[$];
    logic [AW-1:0] outq_a[$];

    function automatic logic [DW-1:0] dval(input logic [AW-1:0] a);
        return {(a & MASK) ^ 32'hA5A5_0000, ~(a & MASK)};
    endfunction

    function automatic string lbl(input string dflt);
        return (phase != "") ? phase : dflt;
    endfunction

    function automatic int pick_victim();
        int v = -1;
        int best = 0;
        for (int i = 0; i < DEP; i++) if (!m_valid[i]) return i;
        for (int i = 0; i < DEP; i++) begin
            if (!m_pend[i] && (v < 0 || m_stamp[i] < best)) begin
                v = i; best = m_stamp[i];
            end
        end
        if (v >= 0) return v;
        for (int i = 0; i < DEP; i++) begin
            if (v < 0 || m_stamp[i] < best) begin
                v = i; best = m_stamp[i];
            end
        end
        return v;
    endfunction

    task automatic fail_line(input string req, input string what,
                             input logic [DW-1:0] act, input logic [DW-1:0] exp);
        fails++;
        $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    endtask

    // reference model, one step per clock edge
    always @(posedge clk) begin
        if (!rst_n) begin
            cyc = 0;
            for (int i = 0; i < DEP; i++) begin
                m_valid[i] = 0; m_pend[i] = 0; m_tag[i] = '0;
                m_data[i] = '0; m_stamp[i] = 0;
            end
            ef_a.delete(); ef_id.delete(); ef_req.delete();
            eh_fake.delete(); eh_d.delete(); eh_req.delete();
        end else begin
            int hit;
            int due;
            int v;
            bit live;
            logic [AW-1:0] key;
            cyc++;
            hit  = -1;
            key  = rd_addr & MASK;
            due  = cyc + TRL - 1;
            live = ret_valid && m_valid[ret_id] && m_pend[ret_id];
            if (rd_valid) begin
                for (int i = 0; i < DEP; i++)
                    if (m_valid[i] && m_tag[i] == key) hit = i;
            end
            if (live) begin
                m_data[ret_id] = ret_data;
                m_pend[ret_id] = 0;
            end
            if (rd_valid) begin
                if (hit < 0) begin
                    // R4 placeholder on first access, R2 forward
                    v = pick_victim();
                    eh_fake[due] = 1; eh_d[due] = FILL; eh_req[due] = lbl("R4");
                    m_valid[v] = 1; m_pend[v] = 1; m_tag[v] = key; m_stamp[v] = cyc;
                    ef_a[cyc] = key; ef_id[cyc] = v; ef_req[cyc] = lbl("R2");
                end else if (!m_pend[hit]) begin
                    // R6 completed hit (data may have landed this very edge: R9)
                    eh_fake[due] = 0; eh_d[due] = m_data[hit];
                    eh_req[due] = (live && ret_id == hit) ? lbl("R9") : lbl("R6");
                    m_valid[hit] = 0;
                end else begin
                    // R8 still awaiting data
                    eh_fake[due] = 1; eh_d[due] = FILL; eh_req[due] = lbl("R8");
                end
            end
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (!rst_n) begin
            checks++;
            if (fwd_valid !== 1'b0 || host_valid !== 1'b0)
                fail_line("R1", "outputs in reset", {fwd_valid, host_valid}, 0);
        end else if (!done) begin
            bit ef;
            bit eh;
            ef = ef_a.exists(cyc);
            eh = eh_d.exists(cyc);
            checks++;
            if (fwd_valid !== ef) fail_line("R2", "fwd_valid", fwd_valid, ef);
            else if (ef) begin
                checks++;
                if (fwd_addr !== ef_a[cyc]) fail_line(ef_req[cyc], "fwd_addr", fwd_addr, ef_a[cyc]);
                checks++;
                if (fwd_id !== IDW'(ef_id[cyc])) fail_line(ef_req[cyc] == "R2" ? "R10" : ef_req[cyc],
                                                          "fwd_id", fwd_id, ef_id[cyc]);
            end
            checks++;
            if (host_valid !== eh) fail_line("R3", "host_valid", host_valid, eh);
            else if (eh) begin
                checks++;
                if (host_fake !== eh_fake[cyc] || host_data !== eh_d[cyc])
                    fail_line(eh_req[cyc], "host beat", {host_fake, host_data[DW-2:0]},
                              {eh_fake[cyc], eh_d[cyc][DW-2:0]});
            end
            if (fwd_valid) begin
                id_of[fwd_addr] = fwd_id;
                outq_id.push_back(fwd_id);
                outq_a.push_back(fwd_addr);
            end
        end
    end

    task automatic drive(input bit rv, input logic [AW-1:0] ra, input bit tv,
                         input int tid, input logic [DW-1:0] td);
        @(negedge clk); #1;
        rd_valid = rv; rd_addr = ra; ret_valid = tv; ret_id = IDW'(tid); ret_data = td;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(0, '0, 0, 0, '0);
    endtask

    task automatic rd(input logic [AW-1:0] a);
        drive(1, a, 0, 0, '0);
    endtask

    task automatic ret(input logic [AW-1:0] a);
        drive(0, '0, 1, id_of[a & MASK], dval(a));
    endtask

    task automatic do_reset();
        idle(TRL + 2);
        @(negedge clk); #1;
        rst_n = 0; rd_valid = 0; ret_valid = 0;
        idle(3);
        id_of.delete(); outq_id.delete(); outq_a.delete();
        rst_n = 1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R3 watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [AW-1:0] a_a = 32'h0000_0100;
        logic [AW-1:0] a_b = 32'h0000_0200;
        logic [AW-1:0] a_c = 32'h0000_0300;
        logic [AW-1:0] a_d = 32'h0000_0400;
        idle(3);
        rst_n = 1;
        idle(1);

        // R1/R4/R2: first read after reset is a miss with placeholder
        phase = "R1"; rd(a_a); phase = ""; idle(2); ret(a_a); idle(TRL);
        // R7: alias hits the same entry and returns the line
        phase = "R7"; rd(a_a | ALIAS); idle(1);
        // R6: entry freed, next read misses
        phase = "R6"; rd(a_a); phase = ""; idle(2); ret(a_a); idle(TRL);

        // R8: second read before data is back
        rd(a_b); phase = "R8"; rd(a_b | ALIAS); phase = ""; idle(1); ret(a_b); idle(2);
        rd(a_b); idle(TRL);

        // R9: return and hit on the same entry in one cycle
        rd(a_c); idle(2);
        phase = "R9"; drive(1, a_c | ALIAS, 1, id_of[a_c], dval(a_c)); phase = ""; idle(TRL);

        // R5: stray return to a completed entry is ignored
        rd(a_d); idle(2); ret(a_d); idle(1);
        drive(0, '0, 1, id_of[a_d], 64'hDEAD_BEEF_0BAD_F00D); idle(1);
        phase = "R5"; rd(a_d); phase = ""; idle(TRL);

        // R10/R11: pressure on all entries
        do_reset();
        phase = "R10";
        for (int i = 0; i < DEP; i++) rd(32'h1000 + i * 32'h40);
        idle(2);
        for (int i = 1; i < DEP; i++) ret(32'h1000 + i * 32'h40);
        idle(1);
        rd(32'h1000 + DEP * 32'h40);
        idle(2);
        ret(32'h1000);
        ret(32'h1000 + DEP * 32'h40);
        idle(1);
        phase = "R11";
        rd(32'h1040);
        idle(2); ret(32'h1040); idle(1);
        rd(32'h1040 | ALIAS);
        phase = "";
        idle(TRL);

        // random traffic with out-of-order returns
        for (int n = 0; n < 400; n++) begin
            bit rv;
            bit tv;
            int tid;
            logic [AW-1:0] ra;
            logic [AW-1:0] ta;
            rv = ($urandom_range(0, 9) < 6);
            ra = 32'h8000 + 32'h40 * $urandom_range(0, 7);
            if ($urandom_range(0, 1) == 1) ra = ra | ALIAS;
            tv = 0; tid = 0; ta = '0;
            if (outq_id.size() > 0 && $urandom_range(0, 9) < 4) begin
                int k;
                k = $urandom_range(0, outq_id.size() - 1);
                tv = 1; tid = outq_id[k]; ta = outq_a[k];
                outq_id.delete(k); outq_a.delete(k);
            end
            drive(rv, ra, tv, tid, dval(ta));
        end
        idle(TRL + 3);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule